// File: doc/BRIEF.md
# Flash Page Program Receive Buffer

This block is the device-side receiver for the program path of a serial flash. It watches a single-lane SPI link (active-low chip select, serial clock, one data line) by oversampling it in the system clock domain. Each transaction starts with an 8-bit opcode. An external decoder reports what that opcode means through a two-bit command input. For a program command, three address bytes follow and then any number of data bytes. The data bytes are placed into a 256-entry page buffer. The first byte goes to the index given by the low address byte, and later bytes take the following indices, wrapping inside the page.

Every entry written during a transaction is marked in a per-entry written mask. When chip select is released after at least one complete data byte, the block pulses a commit strobe for one clock. The same event updates the committed page base address and the security register slot. The array-programming engine then reads the buffer and the mask through a random-access read port. A security register program must name slot 1, 2 or 3 through fixed values of the upper address bytes. Any other address raises an error flag and suppresses the commit.

Top module: `page_prog_buf`

## Requirements
- R1: Serial bits are taken on each rising edge of `sck` while `cs_n` is low, most significant bit first. The first byte of a transaction is the opcode, the next three bytes form the 24-bit address (high byte first), and every later byte is data.
- R2: `cmd_sel` is sampled when the eighth opcode bit is taken. The encoding is 2'b01 = page program and 2'b10 = security register program. Values 2'b00 and 2'b11 are not program commands: the rest of the transaction writes nothing, sets no mask bit and gives no commit.
- R3: The k-th complete data byte (k counted from 0) is stored at index (address[7:0] + k) mod 256, and the mask bit of that index is set. `rd_data` and `rd_mark` show the entry and mask bit selected by `rd_idx`.
- R4: When more than 256 data bytes arrive, the index wraps to the start of the same page, and each later byte overwrites the earlier content at its index.
- R5: After `cs_n` rises, `commit_pulse` is high for exactly one clock, but only if the transaction was a valid program command that received at least one complete data byte. With that pulse, `commit_addr` becomes {address[23:8], 8'h00}.
- R6: Bits of an incomplete final byte are discarded at chip-select release. They are not stored, do not set a mask bit and do not count toward the one-byte minimum.
- R7: A security register program is valid when address[23:16] = 8'h00 and address[15:8] is 8'h10, 8'h20 or 8'h30. On commit, `commit_sec` is 1, 2 or 3 for these cases, and 0 for a page program.
- R8: For a security register program with any other upper address, `sec_err` goes high once the address is complete and stays high until the next falling edge of `cs_n`. That transaction stores no data and does not commit.
- R9: The whole written mask clears when a new transaction begins (`cs_n` falls). After release the mask holds until then. Buffer contents are never cleared, so entries not written by a transaction keep their old values.
- R10: After reset, `commit_pulse` and `sec_err` are 0, every mask bit is 0, `commit_addr` is 0 and `commit_sec` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| cmd_sel | input | 2 | Decoded command class for the current opcode |
| rd_idx | input | PAGE_BITS | Buffer read index |
| rd_data | output | 8 | Buffer byte at `rd_idx` |
| rd_mark | output | 1 | Written-mask bit at `rd_idx` |
| commit_pulse | output | 1 | One-clock strobe after a committable transaction |
| commit_addr | output | 8*ADDR_BYTES | Page base address of the last commit |
| commit_sec | output | 2 | Security register slot of the last commit, 0 for the main array |
| sec_err | output | 1 | Invalid security register address in the current/last transaction |

## Verification
The bench builds the block with its default values: two synchronizer stages, three address bytes and an 8-bit page index, which gives the full 256-entry page. With the full page, a directed 300-byte burst starting near the top of the page can be used to show the wrap and the overwrite of earlier bytes. The serial clock runs at one quarter of the system clock, which keeps each edge well apart after two synchronizer stages. Random transactions mix page and security targets, lengths from zero to several dozen bytes, and incomplete final bytes. These are checked against a bench model of the buffer, the mask, the commit strobe and the error flag.

// File: rtl/ppb_pkg.sv
`timescale 1ns/1ps
package ppb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_OPC  = 3'd1,
    ST_ADDR = 3'd2,
    ST_DATA = 3'd3,
    ST_SKIP = 3'd4
  } ppb_state_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_PAGE = 2'd1,
    CMD_SECR = 2'd2,
    CMD_RSVD = 2'd3
  } ppb_cmd_e;

  localparam int BYTE_W = 8;

  // Slot number of a security register target, 0 when the address names none.
  function automatic logic [1:0] sec_slot(input logic hi_zero, input logic [7:0] mid);
    logic [1:0] s;
    s = 2'd0;
    if (hi_zero) begin
      case (mid)
        8'h10:   s = 2'd1;
        8'h20:   s = 2'd2;
        8'h30:   s = 2'd3;
        default: s = 2'd0;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/ppb_pin_sync.sv
`timescale 1ns/1ps
module ppb_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic mosi_i,
  output logic cs_start_o,
  output logic cs_end_o,
  output logic bit_stb_o,
  output logic bit_val_o
);

  logic [STAGES-1:0] cs_sr;
  logic [STAGES-1:0] sck_sr;
  logic [STAGES-1:0] dat_sr;
  logic              cs_last_q;
  logic              sck_last_q;
  logic              cs_s;
  logic              sck_s;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            cs_sr[0]  <= 1'b1;
            sck_sr[0] <= 1'b0;
            dat_sr[0] <= 1'b0;
          end else begin
            cs_sr[0]  <= cs_n_i;
            sck_sr[0] <= sck_i;
            dat_sr[0] <= mosi_i;
          end
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            cs_sr[g]  <= 1'b1;
            sck_sr[g] <= 1'b0;
            dat_sr[g] <= 1'b0;
          end else begin
            cs_sr[g]  <= cs_sr[g-1];
            sck_sr[g] <= sck_sr[g-1];
            dat_sr[g] <= dat_sr[g-1];
          end
        end
      end
    end
  endgenerate

  assign cs_s  = cs_sr[STAGES-1];
  assign sck_s = sck_sr[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_last_q  <= 1'b1;
      sck_last_q <= 1'b0;
    end else begin
      cs_last_q  <= cs_s;
      sck_last_q <= sck_s;
    end
  end

  assign cs_start_o = cs_last_q & ~cs_s;
  assign cs_end_o   = ~cs_last_q & cs_s;
  assign bit_stb_o  = ~cs_s & sck_s & ~sck_last_q;
  assign bit_val_o  = dat_sr[STAGES-1];

endmodule

// File: rtl/ppb_shifter.sv
`timescale 1ns/1ps
module ppb_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              bit_stb_i,
  input  logic              bit_val_i,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] byte_o
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    sh_d   = {sh_q[BYTE_W-2:0], bit_val_i};
    done_d = 1'b0;
    if (clear_i) begin
      cnt_d = '0;
    end else if (bit_stb_i) begin
      cnt_d  = cnt_q + 1'b1;
      done_d = (cnt_q == CNT_LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
      if (bit_stb_i && !clear_i) begin
        sh_q <= sh_d;
      end
    end
  end

  assign byte_done_o = done_q;
  assign byte_o      = sh_q;

endmodule

// File: rtl/ppb_store.sv
`timescale 1ns/1ps
module ppb_store #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic [IDX_W-1:0]      rd_idx_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic                  rd_mark_o,
  output logic [(1<<IDX_W)-1:0] mask_o
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] cell_q [DEPTH];
  logic [DEPTH-1:0]  mask_q;

  genvar e;
  generate
    for (e = 0; e < DEPTH; e++) begin : g_entry
      logic hit;
      assign hit = wr_en_i && (wr_idx_i == IDX_W'(e));

      // Storage cells carry no reset; only the mask is meaningful after reset.
      always_ff @(posedge clk) begin
        if (hit) begin
          cell_q[e] <= wr_data_i;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mask_q[e] <= 1'b0;
        end else if (clr_i) begin
          mask_q[e] <= 1'b0;
        end else if (hit) begin
          mask_q[e] <= 1'b1;
        end
      end
    end
  endgenerate

  assign rd_data_o = cell_q[rd_idx_i];
  assign rd_mark_o = mask_q[rd_idx_i];
  assign mask_o    = mask_q;

endmodule

// File: rtl/ppb_ctrl.sv
`timescale 1ns/1ps
module ppb_ctrl
  import ppb_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int IDX_W      = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_start_i,
  input  logic                    cs_end_i,
  input  logic                    byte_done_i,
  input  logic [BYTE_W-1:0]       byte_i,
  input  logic [1:0]              cmd_sel_i,
  output logic                    wr_en_o,
  output logic [IDX_W-1:0]        wr_idx_o,
  output logic [BYTE_W-1:0]       wr_data_o,
  output logic                    clr_o,
  output logic                    commit_o,
  output logic [8*ADDR_BYTES-1:0] commit_addr_o,
  output logic [1:0]              commit_sec_o,
  output logic                    sec_err_o
);

  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int CNT_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

  ppb_state_e        state_q, state_d;
  ppb_cmd_e          kind_q, kind_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              got_q, got_d;
  logic              err_q, err_d;
  logic [1:0]        slot_q, slot_d;
  logic              commit_q, commit_d;
  logic [ADDR_W-1:0] caddr_q, caddr_d;
  logic [1:0]        csec_q, csec_d;

  logic [ADDR_W-1:0] addr_full;
  logic [1:0]        slot_now;
  logic              wr_en;
  logic              clr;

  assign addr_full = {addr_q[ADDR_W-9:0], byte_i};
  assign slot_now  = sec_slot(addr_full[ADDR_W-1:16] == '0, addr_full[15:8]);

  always_comb begin
    state_d  = state_q;
    kind_d   = kind_q;
    cnt_d    = cnt_q;
    addr_d   = addr_q;
    idx_d    = idx_q;
    got_d    = got_q;
    err_d    = err_q;
    slot_d   = slot_q;
    commit_d = 1'b0;
    caddr_d  = caddr_q;
    csec_d   = csec_q;
    wr_en    = 1'b0;
    clr      = 1'b0;

    if (cs_start_i) begin
      state_d = ST_OPC;
      cnt_d   = '0;
      got_d   = 1'b0;
      err_d   = 1'b0;
      slot_d  = 2'd0;
      clr     = 1'b1;
    end else if (cs_end_i) begin
      if (state_q == ST_DATA && got_q) begin
        commit_d = 1'b1;
        caddr_d  = {addr_q[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
        csec_d   = slot_q;
      end
      state_d = ST_IDLE;
    end else if (byte_done_i) begin
      case (state_q)
        ST_OPC: begin
          kind_d  = ppb_cmd_e'(cmd_sel_i);
          cnt_d   = '0;
          state_d = (kind_d == CMD_PAGE || kind_d == CMD_SECR) ? ST_ADDR : ST_SKIP;
        end
        ST_ADDR: begin
          addr_d = addr_full;
          if (cnt_q == CNT_LAST) begin
            idx_d = addr_full[IDX_W-1:0];
            if (kind_q == CMD_SECR && slot_now == 2'd0) begin
              err_d   = 1'b1;
              state_d = ST_SKIP;
            end else begin
              slot_d  = (kind_q == CMD_SECR) ? slot_now : 2'd0;
              state_d = ST_DATA;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          wr_en = 1'b1;
          idx_d = idx_q + 1'b1;
          got_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      kind_q   <= CMD_NONE;
      cnt_q    <= '0;
      addr_q   <= '0;
      idx_q    <= '0;
      got_q    <= 1'b0;
      err_q    <= 1'b0;
      slot_q   <= 2'd0;
      commit_q <= 1'b0;
      caddr_q  <= '0;
      csec_q   <= 2'd0;
    end else begin
      state_q  <= state_d;
      kind_q   <= kind_d;
      cnt_q    <= cnt_d;
      addr_q   <= addr_d;
      idx_q    <= idx_d;
      got_q    <= got_d;
      err_q    <= err_d;
      slot_q   <= slot_d;
      commit_q <= commit_d;
      caddr_q  <= caddr_d;
      csec_q   <= csec_d;
    end
  end

  assign wr_en_o       = wr_en;
  assign wr_idx_o      = idx_q;
  assign wr_data_o     = byte_i;
  assign clr_o         = clr;
  assign commit_o      = commit_q;
  assign commit_addr_o = caddr_q;
  assign commit_sec_o  = csec_q;
  assign sec_err_o     = err_q;

endmodule

// File: rtl/page_prog_buf.sv
`timescale 1ns/1ps
module page_prog_buf
  import ppb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_BYTES  = 3,
  parameter int PAGE_BITS   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    sck,
  input  logic                    mosi,
  input  logic [1:0]              cmd_sel,
  input  logic [PAGE_BITS-1:0]    rd_idx,
  output logic [7:0]              rd_data,
  output logic                    rd_mark,
  output logic                    commit_pulse,
  output logic [8*ADDR_BYTES-1:0] commit_addr,
  output logic [1:0]              commit_sec,
  output logic                    sec_err
);

  localparam int DEPTH = 1 << PAGE_BITS;

  logic [1:0]           rst_sr;
  logic                 rst_int_n;
  logic                 cs_start;
  logic                 cs_end;
  logic                 bit_stb;
  logic                 bit_val;
  logic                 byte_done;
  logic [BYTE_W-1:0]    byte_val;
  logic                 wr_en;
  logic [PAGE_BITS-1:0] wr_idx;
  logic [BYTE_W-1:0]    wr_data;
  logic                 clr_mask;
  logic [DEPTH-1:0]     mask_vec;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sr <= 2'b00;
    end else begin
      rst_sr <= {rst_sr[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sr[1];

  ppb_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cs_n_i     (cs_n),
    .sck_i      (sck),
    .mosi_i     (mosi),
    .cs_start_o (cs_start),
    .cs_end_o   (cs_end),
    .bit_stb_o  (bit_stb),
    .bit_val_o  (bit_val)
  );

  ppb_shifter #(.BYTE_W(BYTE_W)) i_shift (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .clear_i     (cs_start),
    .bit_stb_i   (bit_stb),
    .bit_val_i   (bit_val),
    .byte_done_o (byte_done),
    .byte_o      (byte_val)
  );

  ppb_ctrl #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(PAGE_BITS)) i_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .cs_start_i    (cs_start),
    .cs_end_i      (cs_end),
    .byte_done_i   (byte_done),
    .byte_i        (byte_val),
    .cmd_sel_i     (cmd_sel),
    .wr_en_o       (wr_en),
    .wr_idx_o      (wr_idx),
    .wr_data_o     (wr_data),
    .clr_o         (clr_mask),
    .commit_o      (commit_pulse),
    .commit_addr_o (commit_addr),
    .commit_sec_o  (commit_sec),
    .sec_err_o     (sec_err)
  );

  ppb_store #(.IDX_W(PAGE_BITS), .DATA_W(BYTE_W)) i_store (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr_i     (clr_mask),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data),
    .rd_mark_o (rd_mark),
    .mask_o    (mask_vec)
  );

endmodule

// File: rtl/ppb_checker.sv
`timescale 1ns/1ps
module ppb_checker #(
  parameter int IDX_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  clr,
  input logic                  wr_en,
  input logic [IDX_W-1:0]      wr_idx,
  input logic [(1<<IDX_W)-1:0] mask,
  input logic                  commit,
  input logic                  cs_end,
  input logic                  sec_err
);

  // R5: strobe lasts a single clock
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  // R5: strobe only follows a detected chip-select release
  a_r5_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(cs_end));

  // R8: an address error never coexists with a commit
  a_r8_err_blocks_commit: assert property (@(posedge clk) disable iff (!rst_n)
    sec_err |-> !commit);

  // R9: starting a transaction empties the whole mask
  a_r9_mask_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mask == '0));

  // R9: clearing and storing never happen in the same cycle
  a_r9_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && wr_en));

  // R3: a stored byte marks its index
  a_r3_write_marks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mask[$past(wr_idx)]);

  // R3: at most one index is marked per cycle
  a_r3_one_mark_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ($countones(mask & ~$past(mask)) <= 1));

endmodule

bind page_prog_buf ppb_checker #(.IDX_W(PAGE_BITS)) i_ppb_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .clr     (clr_mask),
  .wr_en   (wr_en),
  .wr_idx  (wr_idx),
  .mask    (mask_vec),
  .commit  (commit_pulse),
  .cs_end  (cs_end),
  .sec_err (sec_err)
);

// File: tb/test_page_prog_buf.sv
`timescale 1ns/1ps
module test_page_prog_buf;

  logic        clk;
  logic        rst_n;
  logic        cs_n;
  logic        sck;
  logic        mosi;
  logic [1:0]  cmd_sel;
  logic [7:0]  rd_idx;
  logic [7:0]  rd_data;
  logic        rd_mark;
  logic        commit_pulse;
  logic [23:0] commit_addr;
  logic [1:0]  commit_sec;
  logic        sec_err;

  int total = 0;
  int bad   = 0;
  int npulse = 0;
  bit done_flag = 0;

  logic [7:0] txbuf [512];
  logic [7:0] exp_mem [256];
  bit         exp_mask [256];
  bit         exp_known [256];

  page_prog_buf i_page_prog_buf (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .sck          (sck),
    .mosi         (mosi),
    .cmd_sel      (cmd_sel),
    .rd_idx       (rd_idx),
    .rd_data      (rd_data),
    .rd_mark      (rd_mark),
    .commit_pulse (commit_pulse),
    .commit_addr  (commit_addr),
    .commit_sec   (commit_sec),
    .sec_err      (sec_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (commit_pulse) npulse++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] model_slot(input logic [23:0] a);
    if (a[23:16] != 8'h00) return 2'd0;
    if (a[15:8] == 8'h10) return 2'd1;
    if (a[15:8] == 8'h20) return 2'd2;
    if (a[15:8] == 8'h30) return 2'd3;
    return 2'd0;
  endfunction

  task automatic sck_bit(input logic b);
    mosi = b;
    repeat (2) @(negedge clk);
    sck = 1'b1;
    repeat (2) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) sck_bit(b[i]);
  endtask

  task automatic run_txn(input logic [1:0] sel, input logic [23:0] addr, input int n, input int part);
    npulse = 0;
    cmd_sel = sel;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    send_byte(8'($urandom));
    send_byte(addr[23:16]);
    send_byte(addr[15:8]);
    send_byte(addr[7:0]);
    for (int k = 0; k < n; k++) send_byte(txbuf[k]);
    for (int b = 0; b < part; b++) sck_bit(txbuf[n][7-b]);
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic scan(input string tag);
    int mbad = 0;
    int dbad = 0;
    logic [7:0] fa = 0, fe = 0;
    for (int i = 0; i < 256; i++) begin
      rd_idx = i[7:0];
      #0.2;
      if (rd_mark !== exp_mask[i]) mbad++;
      if (exp_known[i] && rd_data !== exp_mem[i]) begin
        if (dbad == 0) begin fa = rd_data; fe = exp_mem[i]; end
        dbad++;
      end
    end
    chk(mbad == 0, {tag, " R3 R9 mask mismatches"}, mbad, 0);
    chk(dbad == 0, {tag, " R1 R4 buffer data"}, fa, fe);
  endtask

  task automatic txn_check(input logic [1:0] sel, input logic [23:0] addr, input int n, input int part, input string tag);
    bit prog, valid, want_err, want_commit;
    logic [1:0] slot;
    for (int k = 0; k <= n; k++) txbuf[k] = 8'($urandom);
    slot     = model_slot(addr);
    prog     = (sel == 2'b01) || (sel == 2'b10);
    valid    = (sel == 2'b01) || (sel == 2'b10 && slot != 2'd0);
    want_err = (sel == 2'b10) && (slot == 2'd0);
    want_commit = valid && (n > 0);
    for (int i = 0; i < 256; i++) exp_mask[i] = 1'b0;
    if (valid) begin
      for (int k = 0; k < n; k++) begin
        exp_mem[(addr[7:0] + k) % 256]   = txbuf[k];
        exp_mask[(addr[7:0] + k) % 256]  = 1'b1;
        exp_known[(addr[7:0] + k) % 256] = 1'b1;
      end
    end
    run_txn(sel, addr, n, part);
    chk(npulse == (want_commit ? 1 : 0), {tag, " R5 R2 R6 commit pulses"}, npulse, want_commit);
    if (want_commit) begin
      chk(commit_addr == {addr[23:8], 8'h00}, {tag, " R5 commit_addr"}, commit_addr, {addr[23:8], 8'h00});
      chk(commit_sec == ((sel == 2'b10) ? slot : 2'd0), {tag, " R7 commit_sec"}, commit_sec,
          (sel == 2'b10) ? slot : 2'd0);
    end
    chk(sec_err == want_err, {tag, " R8 sec_err"}, sec_err, want_err);
    if (!prog) chk(1'b1, {tag, " R2 non-program"}, 0, 0);
    scan(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [1:0]  sel;
    logic [23:0] a;
    int n, part, r;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0; cmd_sel = 2'b00; rd_idx = 8'h00;
    for (int i = 0; i < 256; i++) begin exp_mask[i] = 0; exp_known[i] = 0; exp_mem[i] = 0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R10 reset state
    chk(commit_pulse == 1'b0, "R10 commit_pulse after reset", commit_pulse, 0);
    chk(sec_err == 1'b0, "R10 sec_err after reset", sec_err, 0);
    chk(commit_addr == 24'h0, "R10 commit_addr after reset", commit_addr, 0);
    chk(commit_sec == 2'd0, "R10 commit_sec after reset", commit_sec, 0);
    scan("R10 reset");

    // Directed corners
    txn_check(2'b01, 24'h12_34_10, 5, 0, "R3 page basic");
    txn_check(2'b01, 24'h00_77_F0, 300, 0, "R4 wrap 300 bytes");
    txn_check(2'b01, 24'h00_55_20, 0, 0, "R5 zero data bytes");
    txn_check(2'b01, 24'h00_56_40, 0, 7, "R6 only a partial byte");
    txn_check(2'b01, 24'h0A_0B_80, 2, 5, "R6 two bytes plus partial");
    txn_check(2'b10, 24'h00_10_00, 3, 0, "R7 slot 1");
    txn_check(2'b10, 24'h00_20_FE, 4, 0, "R7 slot 2 wrap");
    txn_check(2'b10, 24'h00_30_33, 1, 0, "R7 slot 3");
    txn_check(2'b10, 24'h00_40_00, 4, 0, "R8 bad middle byte");
    txn_check(2'b10, 24'h01_10_00, 4, 0, "R8 nonzero high byte");
    txn_check(2'b00, 24'h00_00_00, 4, 0, "R2 sel 00");
    txn_check(2'b11, 24'h00_00_08, 4, 0, "R2 sel 11");

    // Random mix
    for (int t = 0; t < 24; t++) begin
      r = $urandom_range(0, 19);
      if (r < 11) begin
        sel = 2'b01; a = 24'($urandom);
      end else if (r < 16) begin
        sel = 2'b10; a = {8'h00, 8'h10 * 8'($urandom_range(1, 3)), 8'($urandom)};
      end else if (r < 18) begin
        sel = 2'b10; a = {8'($urandom_range(0, 1)), 8'h41 + 8'($urandom_range(0, 100)), 8'($urandom)};
      end else begin
        sel = ($urandom_range(0, 1) == 0) ? 2'b00 : 2'b11; a = 24'($urandom);
      end
      n    = $urandom_range(0, 40);
      part = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 7) : 0;
      txn_check(sel, a, n, part, "random R1 R3");
    end

    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule